// File: doc/BRIEF.md
# Double-Buffered Toggle PWM Generator

This block produces an 8-bit pulse-width-modulated waveform from a free-running up-counter and a single output flip-flop. In every counting step the counter is compared against an active compare value. A match toggles the flip-flop. When the counter wraps from its maximum value back to zero, the flip-flop toggles again. The output pin carries the inverse of the flip-flop, so the pin is high at idle and low for the part of each period that follows the match.

The compare value is held in two stages. Software writes a duty value into the front stage at any time with a write strobe. The active stage takes that value only at a period boundary, which is the step in which the counter wraps. Because of this, the duty value can be rewritten freely while the block runs, and no period ever mixes two duty values. When the run bit rises, the front stage is copied into the active stage once. The counter holds at zero for that first cycle, so the first period already uses the loaded value. Every wrap also raises a one-cycle interrupt pulse.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: While rst_n is low at a clock edge, count goes to 0, pwm_n goes to 1 and ovf_irq goes to 0, and both compare stages clear to 0.
- R2: While run is 0, count stays at 0. In the first cycle after run rises, count holds at 0. After that, count rises by exactly 1 in each cycle in which both run and cnt_en are 1.
- R3: When count is 255 and a step occurs, count wraps to 0. ovf_irq is 1 for exactly the one cycle in which count first reads 0 after the wrap, and is 0 at all other times.
- R4: While cnt_en is 0, count and pwm_n keep their values and ovf_irq stays 0.
- R5: With active compare value C, in a running period pwm_n is 1 while count is in 0..C and 0 while count is in C+1..255.
- R6: With C = 255, the match and the wrap fall in the same step and cancel each other, so pwm_n stays 1 for the whole period.
- R7: A write made during a period does not change that period's waveform. The new value takes effect from the next period.
- R8: When several writes land within one period, only the last written value becomes active at the next boundary.
- R9: A value written while run is 0 becomes active when run rises, and it governs the first period.
- R10: When run falls, the next cycle shows count = 0 and pwm_n = 1, whatever the phase of the period was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Counting enable; one counter step per cycle while high |
| run | input | 1 | Start control; a rising edge loads the active compare stage |
| wr_en | input | 1 | Write strobe for the front compare stage |
| wr_data | input | 8 | Duty value written to the front stage |
| pwm_n | output | 1 | Active-low PWM output (inverse of the toggle flip-flop) |
| ovf_irq | output | 1 | One-cycle pulse after each counter wrap |
| count | output | 8 | Current counter value |

## Verification
The bound checker watches the behaviour that holds in every cycle. It checks that an interrupt pulse coincides with a zero count and never lasts two cycles, and that a stopped generator reads zero with the pin high. It also checks that a disabled step leaves the count frozen, that the pin moves only on a match or a wrap step, and that the active compare stage changes only at a wrap or at start. The directed scenarios are the only way to show the actual duty cycle for several compare values, including the cancelling case at 255. They also show that a mid-period write is deferred to the next period, that the last of several writes wins, and that the start edge loads the value written beforehand.

// File: rtl/pwm_pkg.sv
// Package: shared event type for the double-buffered PWM generator.
// Assumes: every event flag is single-cycle and qualified in the top module.
package pwm_pkg;

    // Events decoded once per cycle by the top module
    typedef struct packed {
        logic start;   // first cycle after run rises
        logic step;    // counter advances this cycle
        logic wrap;    // step taken at the maximum count
        logic match;   // step taken at the active compare value
    } pwm_evt_t;

endpackage

// File: rtl/pwm_step_counter.sv
// Module: free-running up-counter that wraps at its maximum value.
// Assumes: clear takes priority over step; reset is synchronous, active low.
module pwm_step_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         at_max
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Advance on step, wrap to zero after the maximum, clear when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (step)
            cnt_q <= (cnt_q == MAX) ? '0 : cnt_q + ONE;
    end

    assign count  = cnt_q;
    assign at_max = (cnt_q == MAX);
endmodule

// File: rtl/pwm_cmp_buffer.sv
// Module: two-stage compare buffer (front stage written by software,
// active stage used by the comparator).
// Assumes: load is asserted only at a period boundary or at start; a write
// in the same cycle as a load lands in the front stage for the next period.
module pwm_cmp_buffer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] act_val
);
    logic [W-1:0] front_q;
    logic [W-1:0] act_q;

    // Front stage: capture every write; the last write in a period wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            front_q <= '0;
        else if (wr_en)
            front_q <= wr_data;
    end

    // Active stage: shift from the front stage only on load
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (load)
            act_q <= front_q;
    end

    assign act_val = act_q;
endmodule

// File: rtl/pwm_toggle_out.sv
// Module: toggle flip-flop and overflow interrupt register.
// Assumes: toggle is already the parity of match and wrap events, so a
// coincident match and wrap leave the flip-flop unchanged.
module pwm_toggle_out (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic toggle,
    input  logic wrap,
    output logic pwm_n,
    output logic ovf_irq
);
    logic ff_q;
    logic irq_q;

    // Output flip-flop: flip on an odd number of events, clear when stopped
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            ff_q <= 1'b0;
        else if (toggle)
            ff_q <= ~ff_q;
    end

    // Interrupt: one-cycle pulse following each wrap step
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= wrap;
    end

    assign pwm_n   = ~ff_q;
    assign ovf_irq = irq_q;
endmodule

// File: rtl/pwm_dbuf_gen.sv
// Module: top of the double-buffered toggle PWM generator.
// Assumes: run is synchronous to clk; the cycle in which run rises is spent
// loading the active stage, so the counter starts stepping one cycle later.
module pwm_dbuf_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         run,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         pwm_n,
    output logic         ovf_irq,
    output logic [W-1:0] count
);
    import pwm_pkg::*;

    logic         run_q;
    logic         at_max;
    logic [W-1:0] act_cmp;
    pwm_evt_t     evt;

    // Run history: marks the first cycle after run rises
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= run;
    end

    // Event decode for this cycle
    always_comb begin
        evt.start = run & ~run_q;
        evt.step  = run & run_q & cnt_en;
        evt.wrap  = evt.step & at_max;
        evt.match = evt.step & (count == act_cmp);
    end

    pwm_step_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (~run),
        .step   (evt.step),
        .count  (count),
        .at_max (at_max)
    );

    pwm_cmp_buffer #(.W(W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .load    (evt.start | evt.wrap),
        .act_val (act_cmp)
    );

    pwm_toggle_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (~run),
        .toggle  (evt.match ^ evt.wrap),
        .wrap    (evt.wrap),
        .pwm_n   (pwm_n),
        .ovf_irq (ovf_irq)
    );
endmodule

// File: rtl/pwm_dbuf_chk.sv
// Module: assertion checker bound to pwm_dbuf_gen.
// Assumes: it keeps its own copy of the run history and uses no design state
// beyond the ports and the active compare stage.
module pwm_dbuf_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         cnt_en,
    input logic         pwm_n,
    input logic         ovf_irq,
    input logic [W-1:0] count,
    input logic [W-1:0] act_cmp
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic run_h;

    // Independent run history for the properties
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_h <= 1'b0;
        else
            run_h <= run;
    end

    // R3
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (count == '0));

    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |=> !ovf_irq);

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0) && pwm_n);

    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_en) |=> $stable(count) && $stable(pwm_n) && !ovf_irq);

    // R5
    pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_h && !(cnt_en && (count == act_cmp || count == MAX)))
        |=> $stable(pwm_n));

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || (run_h && !(cnt_en && count == MAX))) |=> $stable(act_cmp));
endmodule

bind pwm_dbuf_gen pwm_dbuf_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .cnt_en  (cnt_en),
    .pwm_n   (pwm_n),
    .ovf_irq (ovf_irq),
    .count   (count),
    .act_cmp (act_cmp)
);

// File: tb/tb_pwm_dbuf_gen.sv
module tb_pwm_dbuf_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       run = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pwm_n;
    logic       ovf_irq;
    logic [7:0] count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_dbuf_gen dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run(run),
        .wr_en(wr_en), .wr_data(wr_data),
        .pwm_n(pwm_n), .ovf_irq(ovf_irq), .count(count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0; run = 1'b0; cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        check(count == 8'd0, "R1 count", count, 0);
        check(pwm_n == 1'b1, "R1 pwm_n", pwm_n, 1);
        check(ovf_irq == 1'b0, "R1 ovf_irq", ovf_irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R2: counter holds while run is low
    task automatic t_hold();
        repeat (6) @(negedge clk);
        check(count == 8'd0, "R2 idle count", count, 0);
        check(pwm_n == 1'b1, "R2 idle pwm_n", pwm_n, 1);
    endtask

    // One full period starting at a negedge where count should read 0
    task automatic t_period(input logic [7:0] c, input bit irq0,
                            input bit w1, input logic [7:0] v1,
                            input bit w2, input logic [7:0] v2,
                            input int stall_at, input string tag);
        for (int i = 0; i < 256; i++) begin
            check(count == i[7:0], "R2 step", count, i);
            check(pwm_n == ((i > int'(c)) ? 1'b0 : 1'b1), tag, pwm_n, (i > int'(c)) ? 0 : 1);
            check(ovf_irq == (i == 0 && irq0), "R3 irq", ovf_irq, (i == 0 && irq0) ? 1 : 0);
            if (i == stall_at) begin
                logic [7:0] hc;
                logic       hp;
                hc = count; hp = pwm_n;
                cnt_en = 1'b0;
                repeat (4) begin
                    @(negedge clk);
                    check(count == hc, "R4 count frozen", count, hc);
                    check(pwm_n == hp, "R4 pin frozen", pwm_n, hp);
                    check(ovf_irq == 1'b0, "R4 irq", ovf_irq, 0);
                end
                cnt_en = 1'b1;
            end
            wr_en   = (w1 && i == 100) || (w2 && i == 150);
            wr_data = (i == 150) ? v2 : v1;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    // R9: write while stopped, then start
    task automatic t_start(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; run = 1'b1;
        @(negedge clk);
        check(count == 8'd0, "R2 start hold", count, 0);
    endtask

    // R10: stop in the middle of a period
    task automatic t_stop();
        repeat (10) @(negedge clk);
        check(count == 8'd10, "R10 pre-stop count", count, 10);
        check(pwm_n == 1'b0, "R10 pre-stop pin", pwm_n, 0);
        run = 1'b0;
        @(negedge clk);
        check(count == 8'd0, "R10 count", count, 0);
        check(pwm_n == 1'b1, "R10 pin", pwm_n, 1);
        check(ovf_irq == 1'b0, "R10 irq", ovf_irq, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_hold();
        t_start(8'h40);
        t_period(8'h40, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, -1, "R9 first period");
        t_period(8'h40, 1'b1, 1'b1, 8'h80, 1'b0, 8'h00, -1, "R7 write deferred");
        t_period(8'h80, 1'b1, 1'b1, 8'h10, 1'b1, 8'hFF, -1, "R7 new value");
        t_period(8'hFF, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 60, "R8 R6 last write");
        t_period(8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, -1, "R5 zero duty");
        t_stop();
        t_start(8'h20);
        t_period(8'h20, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, -1, "R9 restart");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule